// File: doc/BRIEF.md
# 4:2:2 Component Video Word-Stream Formatter

This block takes luma and colour-difference samples that have already been digitized and packs them into a single 10-bit word stream at the master word rate. Within an active line the words cycle blue-difference, luma, red-difference, luma. There are 720 luma words and 360 words of each colour-difference component, which gives 1440 words per active line. The formatter also produces the stream's line and frame structure. A receiver cannot rebuild blanking and sync from wires, because there are none. It rebuilds them from two in-band timing codes. An end-of-active code opens each line's horizontal blanking, and a start-of-active code closes it just before the samples begin. Every other blanking word carries a neutral fill value that a later stage may overwrite with auxiliary data.

An internal word and line counter steps once for each cycle in which the word-rate enable is high. Three request strobes tell the upstream source which component the next enabled cycle will consume. The source then presents that sample on the matching bus. The standard select chooses between the 525-line raster (1716 words per line, 485 active lines) and the 625-line raster (1728 words per line, 576 active lines). Only the counts differ between the two. The select is taken at frame boundaries. Sample inputs narrower than 10 bits are left-justified.

Top module: `cvid_formatter`

## Requirements
- R1: In an active word slot, the position k after the start-of-active code selects the source: k mod 4 = 0 takes the blue-difference sample, 2 takes the red-difference sample, and 1 and 3 take luma. The strobes need_cb, need_y and need_cr show the current slot's demand and are all low outside active slots.
- R2: A SAMPLE_W-bit sample is placed in the top bits of the 10-bit word, and the low (10 - SAMPLE_W) bits are zero.
- R3: Active words are limited to the range 004h to 3FBh. A justified value below 004h becomes 004h, and a value above 3FBh becomes 3FBh.
- R4: Word positions 0 to 3 of every line carry the end-of-active code 3FFh, 000h, 000h, XYZ with H = 1.
- R5: The four words just before the first active position (positions T-A-4 to T-A-1, where T is the line length and A is the active word count) carry 3FFh, 000h, 000h, XYZ with H = 0.
- R6: The XYZ word has bit 9 = 1, bit 8 = F, bit 7 = V, bit 6 = H, bit 5 = V^H, bit 4 = F^H, bit 3 = F^V, bit 2 = F^V^H, and bits 1:0 = 0.
- R7: V is 0 on lines 0 to (active lines - 1) and 1 on the remaining lines. F is 1 on lines at or above half the frame's line count and 0 below that.
- R8: Every blanking word that is not part of a timing code is 200h at even word positions and 040h at odd ones. This covers the horizontal blanking of all lines and the whole active region of lines with V = 1.
- R9: A line is 1716 words in the 525 mode (std_sel = 0) and 1728 words in the 625 mode (std_sel = 1). Frames are 525 and 625 lines. After the last word of the frame the counter returns to line 0, word 0.
- R10: std_sel is sampled only on the enabled cycle that carries the frame's last word. A change at any other time does not alter the current frame.
- R11: The counter and the output word advance only on cycles with ce high. vid_valid is high exactly in the cycle after a ce cycle, and vid_word holds its value otherwise.
- R12: With each word, vid_active marks active samples, vid_hblank marks positions 0 to T-A-1, and vid_vblank equals V.
- R13: While rst is high, vid_word is 0, vid_valid is 0 and the position is line 0, word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Word-rate enable; one output word per high cycle |
| std_sel | input | 1 | Raster select: 0 = 525-line, 1 = 625-line |
| y_smp | input | SAMPLE_W | Luma sample |
| cb_smp | input | SAMPLE_W | Blue-difference sample |
| cr_smp | input | SAMPLE_W | Red-difference sample |
| vid_word | output | 10 | Multiplexed output word |
| vid_valid | output | 1 | New word present this cycle |
| vid_active | output | 1 | Word is an active sample |
| vid_hblank | output | 1 | Word lies in horizontal blanking (codes included) |
| vid_vblank | output | 1 | Word lies on a vertical blanking line |
| need_cb | output | 1 | Current slot consumes cb_smp |
| need_y | output | 1 | Current slot consumes y_smp |
| need_cr | output | 1 | Current slot consumes cr_smp |

## Verification
The bench runs full frames of a shrunken raster in both modes and compares every word with a model built from word and line arithmetic. The boundary cases are the first and last active lines, where the V bit changes, and the half-frame line, where F changes. A design with an off-by-one in either place emits a wrong XYZ word and wrong parity bits. The bench also pulses the standard select in the middle of a frame: a formatter that applies the select at once breaks the line length partway through the frame. Sample values of 0 and full scale exercise the clamp, which would otherwise let a sample imitate the 3FFh or 000h of a timing code. Enable patterns with gaps show whether words are dropped, repeated or mis-stepped between enabled cycles.

// File: rtl/cvid_pkg.sv
package cvid_pkg;

  localparam int unsigned VW = 10;

  typedef enum logic [2:0] {
    SLOT_EAV  = 3'd0,
    SLOT_SAV  = 3'd1,
    SLOT_FILL = 3'd2,
    SLOT_CB   = 3'd3,
    SLOT_Y    = 3'd4,
    SLOT_CR   = 3'd5
  } slot_e;

  // protected flag word of a timing code
  function automatic logic [VW-1:0] trs_xyz(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  // word idx of the four-word timing code
  function automatic logic [VW-1:0] trs_word(input logic [1:0] idx, input logic f,
                                             input logic v, input logic h);
    logic [VW-1:0] w;
    case (idx)
      2'd0:    w = '1;
      2'd3:    w = trs_xyz(f, v, h);
      default: w = '0;
    endcase
    return w;
  endfunction

  // neutral blanking value: chroma level on even slots, black on odd slots
  function automatic logic [VW-1:0] fill_word(input logic odd);
    return odd ? VW'(10'h040) : VW'(10'h200);
  endfunction

  // keep samples clear of the code values at both ends of the scale
  function automatic logic [VW-1:0] clamp_word(input logic [VW-1:0] w);
    logic [VW-1:0] lo, hi;
    lo = VW'(10'h004);
    hi = VW'(10'h3FB);
    if (w < lo) return lo;
    if (w > hi) return hi;
    return w;
  endfunction

endpackage

// File: rtl/cvid_raster.sv
module cvid_raster #(
  parameter int unsigned LINE_WORDS_A  = 1716,
  parameter int unsigned LINE_WORDS_B  = 1728,
  parameter int unsigned FRAME_LINES_A = 525,
  parameter int unsigned FRAME_LINES_B = 625,
  parameter int unsigned WCW = 11,
  parameter int unsigned LCW = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           std_sel,
  output logic [WCW-1:0] word_cnt,
  output logic [LCW-1:0] line_cnt,
  output logic           std_q,
  output logic           frame_wrap
);

  logic [WCW-1:0] word_last;
  logic [LCW-1:0] line_last;
  logic           line_end;

  always_comb begin
    word_last  = std_q ? WCW'(LINE_WORDS_B - 1) : WCW'(LINE_WORDS_A - 1);
    line_last  = std_q ? LCW'(FRAME_LINES_B - 1) : LCW'(FRAME_LINES_A - 1);
    line_end   = (word_cnt == word_last);
    frame_wrap = line_end && (line_cnt == line_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_cnt <= '0;
      line_cnt <= '0;
      std_q    <= std_sel;
    end else if (ce) begin
      if (line_end) begin
        word_cnt <= '0;
        if (frame_wrap) begin
          line_cnt <= '0;
          std_q    <= std_sel;
        end else begin
          line_cnt <= line_cnt + 1'b1;
        end
      end else begin
        word_cnt <= word_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cvid_slot_decode.sv
module cvid_slot_decode
  import cvid_pkg::*;
#(
  parameter int unsigned ACT_WORDS     = 1440,
  parameter int unsigned LINE_WORDS_A  = 1716,
  parameter int unsigned LINE_WORDS_B  = 1728,
  parameter int unsigned FRAME_LINES_A = 525,
  parameter int unsigned FRAME_LINES_B = 625,
  parameter int unsigned ACT_LINES_A   = 485,
  parameter int unsigned ACT_LINES_B   = 576,
  parameter int unsigned WCW = 11,
  parameter int unsigned LCW = 10
) (
  input  logic [WCW-1:0] word_cnt,
  input  logic [LCW-1:0] line_cnt,
  input  logic           std_q,
  output slot_e          slot,
  output logic [1:0]     code_idx,
  output logic           fld,
  output logic           vbl,
  output logic           hflag,
  output logic           hbl
);

  int unsigned wi, li, act_start, sav_start, half_lines, act_lines, k;

  always_comb begin
    wi         = 32'(word_cnt);
    li         = 32'(line_cnt);
    act_start  = (std_q ? LINE_WORDS_B : LINE_WORDS_A) - ACT_WORDS;
    sav_start  = act_start - 4;
    half_lines = (std_q ? FRAME_LINES_B : FRAME_LINES_A) / 2;
    act_lines  = std_q ? ACT_LINES_B : ACT_LINES_A;
    fld        = (li >= half_lines);
    vbl        = (li >= act_lines);
    hbl        = (wi < act_start);
    hflag      = (wi < 4);
    k          = wi - act_start;
    code_idx   = 2'(wi);
    slot       = SLOT_FILL;
    if (wi < 4) begin
      slot = SLOT_EAV;
    end else if (wi >= sav_start && wi < act_start) begin
      slot     = SLOT_SAV;
      code_idx = 2'(wi - sav_start);
    end else if (!hbl && !vbl) begin
      case (k[1:0])
        2'd0:    slot = SLOT_CB;
        2'd2:    slot = SLOT_CR;
        default: slot = SLOT_Y;
      endcase
    end
  end

endmodule

// File: rtl/cvid_word_mux.sv
module cvid_word_mux
  import cvid_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  slot_e               slot,
  input  logic [1:0]          code_idx,
  input  logic                fld,
  input  logic                vbl,
  input  logic                hflag,
  input  logic                hbl,
  input  logic                odd_pos,
  input  logic [SAMPLE_W-1:0] y_smp,
  input  logic [SAMPLE_W-1:0] cb_smp,
  input  logic [SAMPLE_W-1:0] cr_smp,
  output logic [VW-1:0]       vid_word,
  output logic                vid_valid,
  output logic                vid_active,
  output logic                vid_hblank,
  output logic                vid_vblank
);

  localparam int unsigned JUST = VW - SAMPLE_W;

  logic [SAMPLE_W-1:0] pick;
  logic [VW-1:0]       nxt;
  logic                is_act;

  always_comb begin
    is_act = (slot == SLOT_CB) || (slot == SLOT_Y) || (slot == SLOT_CR);
    case (slot)
      SLOT_CB: pick = cb_smp;
      SLOT_CR: pick = cr_smp;
      default: pick = y_smp;
    endcase
    case (slot)
      SLOT_EAV, SLOT_SAV: nxt = trs_word(code_idx, fld, vbl, hflag);
      SLOT_FILL:          nxt = fill_word(odd_pos);
      default:            nxt = clamp_word(VW'(pick) << JUST);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_word   <= '0;
      vid_valid  <= 1'b0;
      vid_active <= 1'b0;
      vid_hblank <= 1'b0;
      vid_vblank <= 1'b0;
    end else begin
      vid_valid <= ce;
      if (ce) begin
        vid_word   <= nxt;
        vid_active <= is_act;
        vid_hblank <= hbl;
        vid_vblank <= vbl;
      end
    end
  end

endmodule

// File: rtl/cvid_formatter.sv
module cvid_formatter
  import cvid_pkg::*;
#(
  parameter int unsigned ACT_WORDS     = 1440,
  parameter int unsigned LINE_WORDS_A  = 1716,
  parameter int unsigned LINE_WORDS_B  = 1728,
  parameter int unsigned FRAME_LINES_A = 525,
  parameter int unsigned FRAME_LINES_B = 625,
  parameter int unsigned ACT_LINES_A   = 485,
  parameter int unsigned ACT_LINES_B   = 576,
  parameter int unsigned SAMPLE_W      = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ce,
  input  logic                std_sel,
  input  logic [SAMPLE_W-1:0] y_smp,
  input  logic [SAMPLE_W-1:0] cb_smp,
  input  logic [SAMPLE_W-1:0] cr_smp,
  output logic [9:0]          vid_word,
  output logic                vid_valid,
  output logic                vid_active,
  output logic                vid_hblank,
  output logic                vid_vblank,
  output logic                need_cb,
  output logic                need_y,
  output logic                need_cr
);

  localparam int unsigned MAX_WORDS = (LINE_WORDS_A > LINE_WORDS_B) ? LINE_WORDS_A : LINE_WORDS_B;
  localparam int unsigned MAX_LINES = (FRAME_LINES_A > FRAME_LINES_B) ? FRAME_LINES_A : FRAME_LINES_B;
  localparam int unsigned WCW = $clog2(MAX_WORDS);
  localparam int unsigned LCW = $clog2(MAX_LINES);

  logic [WCW-1:0] word_cnt;
  logic [LCW-1:0] line_cnt;
  logic           std_q;
  logic           frame_wrap;
  slot_e          slot;
  logic [1:0]     code_idx;
  logic           fld, vbl, hflag, hbl;
  // named event for the checker: flag word of a start-of-active code
  logic           at_sav_xyz;

  cvid_raster #(
    .LINE_WORDS_A(LINE_WORDS_A), .LINE_WORDS_B(LINE_WORDS_B),
    .FRAME_LINES_A(FRAME_LINES_A), .FRAME_LINES_B(FRAME_LINES_B),
    .WCW(WCW), .LCW(LCW)
  ) u_raster (
    .clk(clk), .rst(rst), .ce(ce), .std_sel(std_sel),
    .word_cnt(word_cnt), .line_cnt(line_cnt), .std_q(std_q), .frame_wrap(frame_wrap)
  );

  cvid_slot_decode #(
    .ACT_WORDS(ACT_WORDS),
    .LINE_WORDS_A(LINE_WORDS_A), .LINE_WORDS_B(LINE_WORDS_B),
    .FRAME_LINES_A(FRAME_LINES_A), .FRAME_LINES_B(FRAME_LINES_B),
    .ACT_LINES_A(ACT_LINES_A), .ACT_LINES_B(ACT_LINES_B),
    .WCW(WCW), .LCW(LCW)
  ) u_decode (
    .word_cnt(word_cnt), .line_cnt(line_cnt), .std_q(std_q),
    .slot(slot), .code_idx(code_idx), .fld(fld), .vbl(vbl), .hflag(hflag), .hbl(hbl)
  );

  cvid_word_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .clk(clk), .rst(rst), .ce(ce),
    .slot(slot), .code_idx(code_idx), .fld(fld), .vbl(vbl), .hflag(hflag), .hbl(hbl),
    .odd_pos(word_cnt[0]),
    .y_smp(y_smp), .cb_smp(cb_smp), .cr_smp(cr_smp),
    .vid_word(vid_word), .vid_valid(vid_valid), .vid_active(vid_active),
    .vid_hblank(vid_hblank), .vid_vblank(vid_vblank)
  );

  always_comb begin
    need_cb    = (slot == SLOT_CB);
    need_y     = (slot == SLOT_Y);
    need_cr    = (slot == SLOT_CR);
    at_sav_xyz = (slot == SLOT_SAV) && (code_idx == 2'd3);
  end

endmodule

// File: rtl/cvid_formatter_chk.sv
module cvid_formatter_chk #(
  parameter int unsigned WCW = 11,
  parameter int unsigned LCW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           ce,
  input logic [9:0]     vid_word,
  input logic           vid_valid,
  input logic           vid_active,
  input logic           vid_hblank,
  input logic           vid_vblank,
  input logic           need_cb,
  input logic           need_y,
  input logic           need_cr,
  input logic [WCW-1:0] word_cnt,
  input logic [LCW-1:0] line_cnt,
  input logic           std_q,
  input logic           frame_wrap,
  input logic           at_sav_xyz
);

  p_demand_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({need_cb, need_y, need_cr}));

  p_active_clamped_r3: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && vid_active) |-> (vid_word >= 10'h004 && vid_word <= 10'h3FB));

  p_eav_lead_r4: assert property (@(posedge clk) disable iff (rst)
    (ce && word_cnt == '0) |=> (vid_word == 10'h3FF && vid_hblank));

  p_sav_flag_r5: assert property (@(posedge clk) disable iff (rst)
    (ce && at_sav_xyz) |=> (vid_word[9] && !vid_word[6] && vid_word[1:0] == 2'b00));

  p_frame_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (ce && frame_wrap) |=> (word_cnt == '0 && line_cnt == '0));

  p_std_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !(ce && frame_wrap) |=> $stable(std_q));

  p_valid_on_ce_r11: assert property (@(posedge clk) disable iff (rst)
    ce |=> vid_valid);

  p_word_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ce |=> (!vid_valid && $stable(vid_word)));

  p_flag_exclusive_r12: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && vid_active) |-> (!vid_hblank && !vid_vblank));

endmodule

bind cvid_formatter cvid_formatter_chk #(.WCW(WCW), .LCW(LCW)) u_chk (
  .clk(clk), .rst(rst), .ce(ce),
  .vid_word(vid_word), .vid_valid(vid_valid), .vid_active(vid_active),
  .vid_hblank(vid_hblank), .vid_vblank(vid_vblank),
  .need_cb(need_cb), .need_y(need_y), .need_cr(need_cr),
  .word_cnt(word_cnt), .line_cnt(line_cnt), .std_q(std_q),
  .frame_wrap(frame_wrap), .at_sav_xyz(at_sav_xyz)
);

// File: tb/cvid_formatter_bench.sv
module cvid_formatter_bench;

  localparam int ACT = 8;
  localparam int TA  = 20;
  localparam int TB  = 24;
  localparam int LA  = 6;
  localparam int LB  = 8;
  localparam int ALA = 4;
  localparam int ALB = 5;
  localparam int SW  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b0;
  logic          std_sel = 1'b0;
  logic [SW-1:0] y_smp = '0, cb_smp = '0, cr_smp = '0;
  logic [9:0]    vid_word;
  logic          vid_valid, vid_active, vid_hblank, vid_vblank;
  logic          need_cb, need_y, need_cr;

  always #2 clk = ~clk;

  cvid_formatter #(
    .ACT_WORDS(ACT), .LINE_WORDS_A(TA), .LINE_WORDS_B(TB),
    .FRAME_LINES_A(LA), .FRAME_LINES_B(LB),
    .ACT_LINES_A(ALA), .ACT_LINES_B(ALB), .SAMPLE_W(SW)
  ) u_cvid_formatter (
    .clk(clk), .rst(rst), .ce(ce), .std_sel(std_sel),
    .y_smp(y_smp), .cb_smp(cb_smp), .cr_smp(cr_smp),
    .vid_word(vid_word), .vid_valid(vid_valid), .vid_active(vid_active),
    .vid_hblank(vid_hblank), .vid_vblank(vid_vblank),
    .need_cb(need_cb), .need_y(need_y), .need_cr(need_cr)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  int    mw = 0, ml = 0, seed = 0;
  bit    mstd = 0, prev_ce = 0;
  int    exp_word = 0, exp_act = 0, exp_hb = 0, exp_vb = 0, last_word = 0;
  string exp_tag = "";

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 cb, 2 y, 3 cr for position (w,l)
  function automatic int slot_of(input int w, input int l, input bit s);
    int blank = (s ? TB : TA) - ACT;
    int al    = s ? ALB : ALA;
    int k;
    if (w < blank || l >= al) return 0;
    k = (w - blank) % 4;
    return (k == 0) ? 1 : (k == 2) ? 3 : 2;
  endfunction

  function automatic int ref_word(input int w, input int l, input bit s,
                                  input int yv, input int cbv, input int crv,
                                  output string tag);
    int blank = (s ? TB : TA) - ACT;
    int f = (l >= (s ? LB : LA) / 2) ? 1 : 0;
    int v = (l >= (s ? ALB : ALA)) ? 1 : 0;
    int h, k, sl, smp, r;
    if (w < 4 || (w >= blank - 4 && w < blank)) begin
      h   = (w < 4) ? 1 : 0;
      k   = (w < 4) ? w : w - (blank - 4);
      tag = h ? "R4 R6 R7 end-code" : "R5 R6 R7 start-code";
      if (k == 0) return 1023;
      if (k < 3) return 0;
      return 512 + f * 256 + v * 128 + h * 64 + (v ^ h) * 32 + (f ^ h) * 16
             + (f ^ v) * 8 + (f ^ v ^ h) * 4;
    end
    sl = slot_of(w, l, s);
    if (sl == 0) begin
      tag = "R8 fill";
      return (w % 2 == 1) ? 64 : 512;
    end
    smp = (sl == 1) ? cbv : (sl == 3) ? crv : yv;
    r   = smp * (1 << (10 - SW));
    tag = "R1 R2 sample";
    if (r < 4) begin r = 4; tag = "R3 clamp low"; end
    if (r > 1019) begin r = 1019; tag = "R3 clamp high"; end
    return r;
  endfunction

  task automatic step(input bit ce_v, input bit std_v);
    int sl;
    @(negedge clk);
    if (prev_ce) begin
      check(exp_tag, int'(vid_word), exp_word);
      check("R11 valid after ce", int'(vid_valid), 1);
      check("R12 active flag", int'(vid_active), exp_act);
      check("R12 hblank flag", int'(vid_hblank), exp_hb);
      check("R12 vblank flag", int'(vid_vblank), exp_vb);
      last_word = exp_word;
    end else begin
      check("R11 valid low without ce", int'(vid_valid), 0);
      check("R11 word held", int'(vid_word), last_word);
    end
    sl = slot_of(mw, ml, mstd);
    check("R1 demand strobes", int'({need_cb, need_y, need_cr}),
          (sl == 1) ? 4 : (sl == 2) ? 2 : (sl == 3) ? 1 : 0);
    ce      = ce_v;
    std_sel = std_v;
    y_smp   = (seed % 5 == 0) ? 8'd0 : (seed % 5 == 1) ? 8'd255 : 8'(seed * 37);
    cb_smp  = (seed % 3 == 0) ? 8'd255 : 8'(seed * 53);
    cr_smp  = (seed % 4 == 1) ? 8'd0 : 8'(seed * 71);
    if (ce_v) begin
      exp_word = ref_word(mw, ml, mstd, int'(y_smp), int'(cb_smp), int'(cr_smp), exp_tag);
      if (mw == 0 && ml == 0) exp_tag = "R9 R10 frame start code";
      exp_act = (slot_of(mw, ml, mstd) != 0) ? 1 : 0;
      exp_hb  = (mw < (mstd ? TB : TA) - ACT) ? 1 : 0;
      exp_vb  = (ml >= (mstd ? ALB : ALA)) ? 1 : 0;
      seed++;
      mw++;
      if (mw == (mstd ? TB : TA)) begin
        mw = 0;
        ml++;
        if (ml == (mstd ? LB : LA)) begin
          ml   = 0;
          mstd = std_v;  // R10: select taken only at the wrap
        end
      end
    end
    prev_ce = ce_v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check("R13 reset word", int'(vid_word), 0);
    check("R13 reset valid", int'(vid_valid), 0);
    check("R13 reset position (no demand)", int'({need_cb, need_y, need_cr}), 0);
    rst = 1'b0;
    // 525-style frames; mid-frame select pulse must not act (R10)
    for (int i = 0; i < 2 * TA * LA; i++)
      step(1'b1, (i >= 50 && i < 70) || i >= 2 * TA * LA - 10);
    // 625-style frames with enable gaps (R9, R11)
    for (int i = 0; i < 900; i++)
      step(i % 3 != 2, 1'b1);
    // back to 525-style, different gap pattern
    for (int i = 0; i < 800; i++)
      step(i % 5 != 0, 1'b0);
    step(1'b0, 1'b0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule